// File: doc/BRIEF.md
# Delayed Handshake Signal Channel

This block models one direction of a point-to-point link between two nodes. The sending node pulses a one-hot strobe for one of three line-state symbols: request, acknowledge or idle. The channel delivers that symbol to the receiving node as a one-hot, single-cycle pulse after a fixed propagation delay, which is set by a parameter.

Up to two symbols can be in flight at once. Each has its own saturating age counter, and the channel encodes which ordered pair (or single symbol) is pending in a ten-value occupancy state. The oldest symbol always leaves first.

A send that repeats the newest pending symbol is absorbed, because the line level has not changed. A send that would need a third slot is refused and raises a sticky protocol-error flag. A multi-hot strobe is also refused and raises the same flag.

Top module: `hs_delay_chan`

## Requirements
- R1: After a synchronous active-high reset, the channel is empty, `rcv_o` is zero and `proto_err_o` is low.
- R2: Both `snd_i` and `rcv_o` use bit 0 for request, bit 1 for acknowledge and bit 2 for idle. A symbol sampled on clock edge k into an empty channel appears on `rcv_o` after edge k+DELAY+1.
- R3: Sending the symbol that is currently the newest pending one changes nothing. Its age is not restarted, and it is still delivered only once.
- R4: A different symbol sent while one symbol is pending is added behind it with its age starting at zero. The older symbol keeps its age, so each symbol is delivered DELAY+1 edges after its own send.
- R5: Pending symbols are delivered oldest first, with at most one receive bit set in any cycle. Back-to-back sends give deliveries on consecutive cycles.
- R6: When two symbols are pending, sending a symbol other than the newest one is ignored and sets `proto_err_o`. The two pending symbols are still delivered unchanged.
- R7: A send strobe with more than one bit set is ignored and sets `proto_err_o`.
- R8: A delivery frees its slot on the same edge. A send arriving on the edge where one of two pending symbols is delivered is accepted without error.
- R9: `proto_err_o` stays high until reset.
- R10: Once the channel has drained to empty, both age counters are zero. A following send again takes the full DELAY+1 edges.
- R11: Each delivery is a pulse that lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| snd_i | input | 3 | One-hot send strobe: bit0 request, bit1 acknowledge, bit2 idle |
| rcv_o | output | 3 | One-hot single-cycle delivery pulse, same bit meaning |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench aims at the edges of the two-slot window, where several things can go wrong:

- **Repeated send.** A design that restarts the age on a repeat would deliver late, or deliver the symbol twice.
- **Send in the same cycle as a delivery.** A design that checks capacity before draining would wrongly flag an error and drop the new symbol.
- **Third distinct symbol, or a re-send of the older one.** A design that overwrote a slot would reorder or lose a delivery, or fail to raise the error flag.
- **Send after draining to empty.** Leftover counter values would shorten the delay.

// File: rtl/hs_chan_pkg.sv
package hs_chan_pkg;

   typedef logic [2:0] sym_t;

   localparam sym_t SYM_NONE = 3'b000;
   localparam sym_t SYM_REQ  = 3'b001;
   localparam sym_t SYM_ACK  = 3'b010;
   localparam sym_t SYM_IDLE = 3'b100;

   // Occupancy: empty, three singles, six ordered pairs (older first).
   typedef enum logic [3:0] {
      OCC_EMPTY = 4'd0,
      OCC_R     = 4'd1,
      OCC_A     = 4'd2,
      OCC_I     = 4'd3,
      OCC_RA    = 4'd4,
      OCC_RI    = 4'd5,
      OCC_AR    = 4'd6,
      OCC_AI    = 4'd7,
      OCC_IR    = 4'd8,
      OCC_IA    = 4'd9
   } occ_e;

   function automatic logic occ_is_pair(occ_e o);
      return (o >= OCC_RA);
   endfunction

   // Oldest pending symbol.
   function automatic sym_t occ_head(occ_e o);
      case (o)
         OCC_R, OCC_RA, OCC_RI: return SYM_REQ;
         OCC_A, OCC_AR, OCC_AI: return SYM_ACK;
         OCC_I, OCC_IR, OCC_IA: return SYM_IDLE;
         default:               return SYM_NONE;
      endcase
   endfunction

   // Newest pending symbol (equals head for a single).
   function automatic sym_t occ_tail(occ_e o);
      case (o)
         OCC_R, OCC_AR, OCC_IR: return SYM_REQ;
         OCC_A, OCC_RA, OCC_IA: return SYM_ACK;
         OCC_I, OCC_RI, OCC_AI: return SYM_IDLE;
         default:               return SYM_NONE;
      endcase
   endfunction

   function automatic occ_e occ_one(sym_t s);
      case (s)
         SYM_REQ:  return OCC_R;
         SYM_ACK:  return OCC_A;
         SYM_IDLE: return OCC_I;
         default:  return OCC_EMPTY;
      endcase
   endfunction

   function automatic occ_e occ_two(sym_t older, sym_t newer);
      case ({older, newer})
         {SYM_REQ,  SYM_ACK}:  return OCC_RA;
         {SYM_REQ,  SYM_IDLE}: return OCC_RI;
         {SYM_ACK,  SYM_REQ}:  return OCC_AR;
         {SYM_ACK,  SYM_IDLE}: return OCC_AI;
         {SYM_IDLE, SYM_REQ}:  return OCC_IR;
         {SYM_IDLE, SYM_ACK}:  return OCC_IA;
         default:              return OCC_EMPTY;
      endcase
   endfunction

endpackage

// File: rtl/hs_age_ctr.sv
module hs_age_ctr #(
   parameter int DELAY = 4,
   parameter int AGE_W = $clog2(DELAY + 2)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             zero_i,
   input  logic             take_i,
   input  logic [AGE_W-1:0] take_val_i,
   output logic [AGE_W-1:0] age_o
);

   localparam logic [AGE_W-1:0] AGE_CAP = AGE_W'(DELAY + 1);

   logic [AGE_W-1:0] base;
   logic [AGE_W-1:0] age_q;

   assign base = take_i ? take_val_i : age_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || zero_i)
         age_q <= '0;
      else if (base == AGE_CAP)
         age_q <= base;
      else
         age_q <= base + 1'b1;
   end

   assign age_o = age_q;

endmodule

// File: rtl/hs_occ_fsm.sv
module hs_occ_fsm
   import hs_chan_pkg::*;
#(
   parameter int DELAY = 4,
   parameter int AGE_W = $clog2(DELAY + 2)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  sym_t             snd_i,
   input  logic [AGE_W-1:0] age_head_i,
   output occ_e             occ_o,
   output logic             deliver_o,
   output sym_t             head_sym_o,
   output logic             head_zero_o,
   output logic             head_take_o,
   output logic             tail_zero_o,
   output logic             err_o
);

   localparam logic [AGE_W-1:0] AGE_DUE = AGE_W'(DELAY);

   occ_e occ_q, occ_mid, occ_d;
   logic err_q;
   logic deliver, one_hot, multi_hot, reject, fresh, new_pair;

   always_comb begin
      deliver   = (occ_q != OCC_EMPTY) && (age_head_i == AGE_DUE);
      one_hot   = (snd_i != SYM_NONE) && ((snd_i & (snd_i - 3'd1)) == 3'd0);
      multi_hot = (snd_i != SYM_NONE) && !one_hot;

      // Drain first, then apply the send to what is left.
      if (!deliver)
         occ_mid = occ_q;
      else if (occ_is_pair(occ_q))
         occ_mid = occ_one(occ_tail(occ_q));
      else
         occ_mid = OCC_EMPTY;

      occ_d    = occ_mid;
      reject   = 1'b0;
      fresh    = 1'b0;
      new_pair = 1'b0;
      if (one_hot) begin
         if (occ_mid == OCC_EMPTY) begin
            occ_d = occ_one(snd_i);
            fresh = 1'b1;
         end else if (snd_i != occ_tail(occ_mid)) begin
            if (occ_is_pair(occ_mid)) begin
               reject = 1'b1;
            end else begin
               occ_d    = occ_two(occ_tail(occ_mid), snd_i);
               new_pair = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         occ_q <= OCC_EMPTY;
         err_q <= 1'b0;
      end else begin
         occ_q <= occ_d;
         err_q <= err_q | multi_hot | reject;
      end
   end

   assign occ_o       = occ_q;
   assign deliver_o   = deliver;
   assign head_sym_o  = occ_head(occ_q);
   assign head_zero_o = (occ_d == OCC_EMPTY) || fresh;
   assign head_take_o = deliver && occ_is_pair(occ_q);
   assign tail_zero_o = !occ_is_pair(occ_d) || new_pair;
   assign err_o       = err_q;

   p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      err_q |=> err_q);

   p_repeat_absorbed_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!deliver && occ_q != OCC_EMPTY && snd_i == occ_tail(occ_q)) |=> $stable(occ_q));

   p_third_refused_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!deliver && occ_is_pair(occ_q) && one_hot && snd_i != occ_tail(occ_q))
      |=> (err_q && $stable(occ_q)));

   p_multi_refused_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      multi_hot |=> err_q);

endmodule

// File: rtl/hs_delay_chan.sv
module hs_delay_chan
   import hs_chan_pkg::*;
#(
   parameter int DELAY = 4
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [2:0] snd_i,
   output logic [2:0] rcv_o,
   output logic       proto_err_o
);

   localparam int AGE_W = $clog2(DELAY + 2);
   localparam int SLOTS = 2;

   if (DELAY < 1) begin : g_bad_delay
      $error("hs_delay_chan: DELAY must be at least 1");
   end

   occ_e             occ;
   logic             deliver, head_zero, head_take, tail_zero;
   sym_t             head_sym;
   logic [AGE_W-1:0] slot_age [SLOTS];
   logic [AGE_W-1:0] slot_src [SLOTS];
   logic             slot_zero [SLOTS];
   logic             slot_take [SLOTS];
   logic [2:0]       rcv_q;

   hs_occ_fsm #(.DELAY(DELAY), .AGE_W(AGE_W)) u_fsm (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .snd_i       (snd_i),
      .age_head_i  (slot_age[0]),
      .occ_o       (occ),
      .deliver_o   (deliver),
      .head_sym_o  (head_sym),
      .head_zero_o (head_zero),
      .head_take_o (head_take),
      .tail_zero_o (tail_zero),
      .err_o       (proto_err_o)
   );

   // Slot 0 holds the oldest symbol's age, slot 1 the newer one's.
   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g == 0) begin : g_head
         assign slot_zero[g] = head_zero;
         assign slot_take[g] = head_take;
         assign slot_src[g]  = slot_age[1];
      end else begin : g_tail
         assign slot_zero[g] = tail_zero;
         assign slot_take[g] = 1'b0;
         assign slot_src[g]  = '0;
      end
      hs_age_ctr #(.DELAY(DELAY), .AGE_W(AGE_W)) u_ctr (
         .clk_i      (clk_i),
         .rst_i      (rst_i),
         .zero_i     (slot_zero[g]),
         .take_i     (slot_take[g]),
         .take_val_i (slot_src[g]),
         .age_o      (slot_age[g])
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)
         rcv_q <= '0;
      else
         rcv_q <= deliver ? head_sym : SYM_NONE;
   end

   assign rcv_o = rcv_q;

   p_one_symbol_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(rcv_o));

   p_pulse_changes_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      (rcv_o != 3'b000) |=> (rcv_o != $past(rcv_o)));

   p_head_in_window_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (occ != OCC_EMPTY) |-> (slot_age[0] <= AGE_W'(DELAY)));

   p_due_when_sent_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (rcv_o != 3'b000) |-> ($past(slot_age[0]) == AGE_W'(DELAY)));

   p_empty_cleared_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (occ == OCC_EMPTY) |-> (slot_age[0] == '0 && slot_age[1] == '0));

   p_newer_younger_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      occ_is_pair(occ) |-> (slot_age[1] < slot_age[0]));

endmodule

// File: tb/hs_delay_chan_tb.sv
`timescale 1ns/1ps
module hs_delay_chan_tb;

   localparam int  DLY = 4;
   localparam int  LAT = DLY + 2;   // step offset from send to observed pulse
   localparam real TCK = 8.0;       // 125 MHz

   localparam logic [2:0] NO = 3'b000, RQ = 3'b001, AK = 3'b010, ID = 3'b100;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] snd = 3'b000;
   logic [2:0] rcv_o;
   logic       proto_err_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #(TCK/2) clk = ~clk;

   hs_delay_chan #(.DELAY(DLY)) u_dut (
      .clk_i       (clk),
      .rst_i       (rst),
      .snd_i       (snd),
      .rcv_o       (rcv_o),
      .proto_err_o (proto_err_o)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Check outputs left by the previous edge, then drive the next send.
   task automatic step(input logic [2:0] s, input logic [2:0] er, input logic ee, input string rq);
      @(negedge clk);
      n_chk++;
      if (rcv_o !== er) begin
         n_fail++;
         $display("FAIL %s: rcv_o=%b expected %b", rq, rcv_o, er);
      end
      n_chk++;
      if (proto_err_o !== ee) begin
         n_fail++;
         $display("FAIL %s: proto_err_o=%b expected %b", rq, proto_err_o, ee);
      end
      snd = s;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      snd = NO;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      step(NO, NO, 1'b0, "R1 R9");
   endtask

   task automatic t_basic();   // R2, R11
      for (int i = 0; i <= LAT + 1; i++)
         step(i == 0 ? RQ : NO, i == LAT ? RQ : NO, 1'b0, "R2 R11");
   endtask

   task automatic t_repeat();  // R3
      for (int i = 0; i <= LAT + 3; i++)
         step(i <= 2 ? AK : NO, i == LAT ? AK : NO, 1'b0, "R3");
   endtask

   task automatic t_pair();    // R4
      for (int i = 0; i <= LAT + 3; i++)
         step(i == 0 ? RQ : (i == 2 ? ID : NO),
              i == LAT ? RQ : (i == LAT + 2 ? ID : NO), 1'b0, "R4");
   endtask

   task automatic t_b2b();     // R5
      for (int i = 0; i <= LAT + 2; i++)
         step(i == 0 ? AK : (i == 1 ? RQ : NO),
              i == LAT ? AK : (i == LAT + 1 ? RQ : NO), 1'b0, "R5");
   endtask

   task automatic t_overlap(); // R8
      for (int i = 0; i <= DLY + LAT + 2; i++)
         step(i == 0 ? RQ : (i == 1 ? AK : (i == DLY + 1 ? ID : NO)),
              i == LAT ? RQ : (i == LAT + 1 ? AK : (i == DLY + 1 + LAT ? ID : NO)),
              1'b0, "R8");
   endtask

   task automatic t_after_empty(); // R10
      for (int i = 0; i <= 2 * LAT + 1; i++)
         step(i == 0 ? RQ : (i == LAT ? AK : NO),
              i == LAT ? RQ : (i == 2 * LAT ? AK : NO), 1'b0, "R10");
   endtask

   task automatic t_third(input logic [2:0] third, input string rq); // R6, R9
      for (int i = 0; i <= LAT + 3; i++)
         step(i == 0 ? RQ : (i == 1 ? AK : (i == 2 ? third : NO)),
              i == LAT ? RQ : (i == LAT + 1 ? AK : NO), i >= 3, rq);
      do_reset();
   endtask

   task automatic t_multi();   // R7
      for (int i = 0; i <= LAT + 2; i++)
         step(i == 0 ? 3'b011 : (i == 1 ? 3'b111 : NO), NO, i >= 1, "R7");
      do_reset();
   endtask

   initial begin
      #(TCK * 200000);
      n_fail++;
      $display("FAIL watchdog: run not finished, expected completion before timeout");
      summary();
   end

   initial begin
      do_reset();
      t_basic();
      t_repeat();
      t_pair();
      t_b2b();
      t_overlap();
      t_after_empty();
      t_third(ID, "R6 R9 third symbol");
      t_third(RQ, "R6 R9 older resend");
      t_multi();
      t_basic();
      summary();
   end

endmodule